// File: doc/BRIEF.md
# Saturating 40-bit Multiply-Accumulate Unit with Hardware Repeat

The block multiplies two signed 16-bit operands every clock, widens the 32-bit product to the 40-bit accumulator width, and adds it into a 40-bit accumulator. The eight guard bits above the 32-bit product range let long sums run without overflow. Before the addition the product can be negated or rounded to its upper half. The sum can be clamped to the signed 32-bit range, so results stay representable when they are later narrowed.

A hardware repeat counter lets a controller start a loop of up to 8196 multiply-accumulate steps with a single load. The controller then streams one operand pair per cycle. A one-cycle done pulse marks the cycle in which the final sum is visible. A hold input pauses the loop at any point, for example while an interrupt is serviced. Releasing hold continues the loop from the next iteration without losing the partial sum.

Top module: `sat_mac40`

## Requirements
- R1: A pair is accepted on a rising edge where `opnd_valid` is 1 and `hold` is 0. `acc_out` then shows the old accumulator plus the signed 32-bit product `opnd_a*opnd_b`, sign-extended to 40 bits, one cycle later. Without a valid pair, and with `ctl_clr` low, `acc_out` keeps its value.
- R2: With `ctl_neg`=1 the product is negated before the addition, so it is subtracted from the accumulator.
- R3: With `ctl_rnd`=1 (and `ctl_neg`=0), the product has 2^15 added to it and its low 16 bits cleared before the addition.
- R4: When `ctl_neg` and `ctl_rnd` are both 1, only the negation applies and the rounding is ignored.
- R5: With `ctl_sat`=1, a sum above 2^31-1 is written as 0x007FFFFFFF and a sum below -2^31 is written as 0xFF80000000.
- R6: With `ctl_sat`=0 the accumulator wraps modulo 2^40 (two's complement).
- R7: `ctl_clr`=1 makes the update start from zero instead of the old accumulator. With a valid pair the result is the processed product alone; without one the accumulator becomes 0. It takes effect only when `hold` is 0.
- R8: `rpt_load`=1 while `hold`=0 starts a loop of `rpt_count` iterations, with counts above 8196 treated as 8196. A pair accepted in the load cycle is the first iteration. A count of 0 starts no loop.
- R9: `done` is high for exactly one cycle: the cycle after the final iteration's pair is accepted, the same cycle in which `acc_out` first shows the final sum.
- R10: While `hold`=1 the accumulator and the remaining iteration count are frozen, and `done` stays low. Pairs, clears and loads presented in that time are ignored. After release the loop continues with its next iteration.
- R11: Synchronous reset `rst` sets `acc_out` to 0, `done` to 0 and cancels any loop.
- R12: Pairs accepted while no loop is running are accumulated normally but never raise `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opnd_valid | input | 1 | Operand pair present this cycle |
| opnd_a | input | 16 | Signed multiplicand |
| opnd_b | input | 16 | Signed multiplier |
| ctl_neg | input | 1 | Negate the product before adding |
| ctl_rnd | input | 1 | Round the product to its upper half before adding |
| ctl_sat | input | 1 | Clamp the sum to the signed 32-bit range |
| ctl_clr | input | 1 | Start this update from zero |
| rpt_load | input | 1 | Load the repeat counter |
| rpt_count | input | 14 | Iteration count for the loop |
| hold | input | 1 | Freeze accumulator and repeat counter |
| acc_out | output | 40 | Accumulator value |
| done | output | 1 | One-cycle pulse after the final iteration |

## Verification
The bench builds the block with its default parameters: 16-bit operands, a 40-bit accumulator and an 8196-iteration limit. At these values a loop of 512 full-scale products drives the accumulator exactly onto its sign bit and, run twice, back to zero through the 40-bit wrap. The full-length loop and the clamp of an over-range count to 8196 also fit in roughly nine thousand cycles, so the iteration limit is reached without shrinking it.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int DEF_OP_W    = 16;
    localparam int DEF_ACC_W   = 40;
    localparam int DEF_MAX_RPT = 8196;

    // How the product is shaped before accumulation
    typedef enum logic [1:0] {
        PM_PLAIN = 2'd0,
        PM_NEG   = 2'd1,
        PM_RND   = 2'd2
    } prod_mode_e;

    // Which value the saturation stage selects
    typedef enum logic [1:0] {
        SAT_PASS = 2'd0,
        SAT_HIGH = 2'd1,
        SAT_LOW  = 2'd2
    } sat_sel_e;

    typedef struct packed {
        logic neg;
        logic rnd;
        logic sat;
        logic clr;
    } mac_ctl_t;

    // Negation has priority over rounding
    function automatic prod_mode_e pick_mode(input logic neg, input logic rnd);
        if (neg)
            return PM_NEG;
        else if (rnd)
            return PM_RND;
        else
            return PM_PLAIN;
    endfunction

endpackage

// File: rtl/mac_product.sv
module mac_product #(
    parameter int OP_W  = mac_pkg::DEF_OP_W,
    parameter int ACC_W = mac_pkg::DEF_ACC_W
) (
    input  logic signed [OP_W-1:0]  op_a,
    input  logic signed [OP_W-1:0]  op_b,
    input  mac_pkg::prod_mode_e     mode,
    output logic [ACC_W-1:0]        term
);
    localparam int PW = 2 * OP_W;
    localparam logic [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (OP_W - 1);
    localparam logic [ACC_W-1:0] KEEP_HI  = ~((ACC_W'(1) << OP_W) - ACC_W'(1));

    logic signed [PW-1:0] prod;
    logic [ACC_W-1:0]     wide;
    logic [ACC_W-1:0]     rounded;
    logic [ACC_W-1:0]     negated;

    assign prod = op_a * op_b;

    // Sign extension into the guard bits, only when guard bits exist
    generate
        if (ACC_W > PW) begin : g_guard
            assign wide = {{(ACC_W - PW){prod[PW-1]}}, prod};
        end else begin : g_noguard
            assign wide = prod[ACC_W-1:0];
        end
    endgenerate

    assign rounded = (wide + HALF_LSB) & KEEP_HI;
    assign negated = ACC_W'(0) - wide;

    always_comb begin
        unique case (mode)
            mac_pkg::PM_NEG: term = negated;
            mac_pkg::PM_RND: term = rounded;
            default:         term = wide;
        endcase
    end

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
    parameter int ACC_W = mac_pkg::DEF_ACC_W,
    parameter int SAT_W = 2 * mac_pkg::DEF_OP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic             clr,
    input  logic             sat,
    input  logic [ACC_W-1:0] term,
    output logic [ACC_W-1:0] acc
);
    localparam int GW = ACC_W - SAT_W + 2;
    localparam logic signed [ACC_W:0] POS_LIM = {{GW{1'b0}}, {(SAT_W-1){1'b1}}};
    localparam logic signed [ACC_W:0] NEG_LIM = {{GW{1'b1}}, {(SAT_W-1){1'b0}}};

    logic [ACC_W-1:0]       base;
    logic signed [ACC_W:0]  sum;
    mac_pkg::sat_sel_e      sel;
    logic [ACC_W-1:0]       nxt;

    assign base = clr ? '0 : acc;
    assign sum  = $signed({base[ACC_W-1], base}) + $signed({term[ACC_W-1], term});

    always_comb begin
        sel = mac_pkg::SAT_PASS;
        if (sat) begin
            if (sum > POS_LIM)
                sel = mac_pkg::SAT_HIGH;
            else if (sum < NEG_LIM)
                sel = mac_pkg::SAT_LOW;
        end
    end

    always_comb begin
        unique case (sel)
            mac_pkg::SAT_HIGH: nxt = POS_LIM[ACC_W-1:0];
            mac_pkg::SAT_LOW:  nxt = NEG_LIM[ACC_W-1:0];
            default:           nxt = sum[ACC_W-1:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (upd)
            acc <= nxt;
    end

endmodule

// File: rtl/mac_repeat.sv
module mac_repeat #(
    parameter int MAX_RPT = mac_pkg::DEF_MAX_RPT,
    parameter int CNT_W   = $clog2(MAX_RPT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    input  logic             step,
    output logic             done
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RPT);

    logic [CNT_W-1:0] remaining;
    logic [CNT_W-1:0] loaded;
    logic [CNT_W-1:0] base;
    logic             take;

    assign loaded = (count > LIMIT) ? LIMIT : count;
    assign base   = load ? loaded : remaining;
    assign take   = step && (base != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
            done      <= 1'b0;
        end else if (hold) begin
            done      <= 1'b0;
        end else begin
            remaining <= base - CNT_W'(take);
            done      <= take && (base == CNT_W'(1));
        end
    end

endmodule

// File: rtl/sat_mac40.sv
module sat_mac40 #(
    parameter int OP_W    = mac_pkg::DEF_OP_W,
    parameter int ACC_W   = mac_pkg::DEF_ACC_W,
    parameter int MAX_RPT = mac_pkg::DEF_MAX_RPT,
    localparam int CNT_W  = $clog2(MAX_RPT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             opnd_valid,
    input  logic [OP_W-1:0]  opnd_a,
    input  logic [OP_W-1:0]  opnd_b,
    input  logic             ctl_neg,
    input  logic             ctl_rnd,
    input  logic             ctl_sat,
    input  logic             ctl_clr,
    input  logic             rpt_load,
    input  logic [CNT_W-1:0] rpt_count,
    input  logic             hold,
    output logic [ACC_W-1:0] acc_out,
    output logic             done
);
    localparam int SAT_W = 2 * OP_W;

    mac_pkg::mac_ctl_t   ctl;
    mac_pkg::prod_mode_e mode;
    logic [ACC_W-1:0]    term;
    logic [ACC_W-1:0]    term_g;
    logic                accept;
    logic                upd;

    assign ctl    = '{neg: ctl_neg, rnd: ctl_rnd, sat: ctl_sat, clr: ctl_clr};
    assign mode   = mac_pkg::pick_mode(ctl.neg, ctl.rnd);
    assign accept = opnd_valid && !hold;
    assign upd    = !hold && (opnd_valid || ctl.clr);
    assign term_g = opnd_valid ? term : '0;

    mac_product #(
        .OP_W  (OP_W),
        .ACC_W (ACC_W)
    ) u_prod (
        .op_a (opnd_a),
        .op_b (opnd_b),
        .mode (mode),
        .term (term)
    );

    mac_accum #(
        .ACC_W (ACC_W),
        .SAT_W (SAT_W)
    ) u_acc (
        .clk  (clk),
        .rst  (rst),
        .upd  (upd),
        .clr  (ctl.clr),
        .sat  (ctl.sat),
        .term (term_g),
        .acc  (acc_out)
    );

    mac_repeat #(
        .MAX_RPT (MAX_RPT),
        .CNT_W   (CNT_W)
    ) u_rpt (
        .clk   (clk),
        .rst   (rst),
        .hold  (hold),
        .load  (rpt_load),
        .count (rpt_count),
        .step  (accept),
        .done  (done)
    );

endmodule

// File: rtl/sat_mac40_chk.sv
module sat_mac40_chk #(
    parameter int ACC_W = 40,
    parameter int SAT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             opnd_valid,
    input logic             ctl_sat,
    input logic             ctl_clr,
    input logic             hold,
    input logic [ACC_W-1:0] acc_out,
    input logic             done
);
    localparam logic signed [ACC_W-1:0] HI = {{(ACC_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] LO = {{(ACC_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

    a_r1_idle_keeps_acc: assert property (@(posedge clk) disable iff (rst)
        (!opnd_valid && !ctl_clr) |=> $stable(acc_out));

    a_r5_sat_in_range: assert property (@(posedge clk) disable iff (rst)
        (opnd_valid && !hold && ctl_sat) |=>
            (($signed(acc_out) <= HI) && ($signed(acc_out) >= LO)));

    a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (ctl_clr && !opnd_valid && !hold) |=> (acc_out == '0));

    a_r9_done_after_pair: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(opnd_valid && !hold));

    a_r10_hold_freezes_acc: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(acc_out));

    a_r10_hold_no_done: assert property (@(posedge clk) disable iff (rst)
        hold |=> !done);

endmodule

bind sat_mac40 sat_mac40_chk #(
    .ACC_W (ACC_W),
    .SAT_W (2 * OP_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .opnd_valid (opnd_valid),
    .ctl_sat    (ctl_sat),
    .ctl_clr    (ctl_clr),
    .hold       (hold),
    .acc_out    (acc_out),
    .done       (done)
);

// File: tb/sat_mac40_test.sv
`timescale 1ns/1ps
module sat_mac40_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        opnd_valid;
    logic [15:0] opnd_a, opnd_b;
    logic        ctl_neg, ctl_rnd, ctl_sat, ctl_clr;
    logic        rpt_load;
    logic [13:0] rpt_count;
    logic        hold;
    logic [39:0] acc_out;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;
    logic [39:0] m_acc;

    always #10 clk = ~clk;

    sat_mac40 uut (
        .clk(clk), .rst(rst), .opnd_valid(opnd_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .ctl_neg(ctl_neg), .ctl_rnd(ctl_rnd), .ctl_sat(ctl_sat), .ctl_clr(ctl_clr),
        .rpt_load(rpt_load), .rpt_count(rpt_count), .hold(hold),
        .acc_out(acc_out), .done(done)
    );

    function automatic logic [39:0] m_term(input logic signed [15:0] a, input logic signed [15:0] b,
                                           input bit neg, input bit rnd);
        longint p;
        p = longint'(a) * longint'(b);
        if (neg)
            p = -p;
        else if (rnd)
            p = (p + 64'sd32768) & ~64'sd65535;
        return p[39:0];
    endfunction

    function automatic logic [39:0] m_next(input logic [39:0] acc, input logic [39:0] term,
                                           input bit sat, input bit clr);
        longint s;
        s = (clr ? 64'sd0 : longint'($signed(acc))) + longint'($signed(term));
        if (sat) begin
            if (s > 64'sd2147483647)
                s = 64'sd2147483647;
            else if (s < -64'sd2147483648)
                s = -64'sd2147483648;
        end
        return s[39:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        opnd_valid = 0; opnd_a = 0; opnd_b = 0;
        ctl_neg = 0; ctl_rnd = 0; ctl_sat = 0; ctl_clr = 0;
        rpt_load = 0; rpt_count = 0; hold = 0;
    endtask

    // One accepted pair; updates the model and checks the accumulator
    task automatic pair(input logic signed [15:0] a, input logic signed [15:0] b,
                        input bit neg, input bit rnd, input bit sat, input bit clr,
                        input bit load, input logic [13:0] cnt, input string tag);
        opnd_valid = 1; opnd_a = a; opnd_b = b;
        ctl_neg = neg; ctl_rnd = rnd; ctl_sat = sat; ctl_clr = clr;
        rpt_load = load; rpt_count = cnt;
        tick();
        m_acc = m_next(m_acc, m_term(a, b, neg, rnd), sat, clr);
        chk(acc_out == m_acc, tag, acc_out, m_acc);
        quiet();
    endtask

    task automatic t_reset();
        quiet();
        rst = 1;
        repeat (3) tick();
        rst = 0;
        m_acc = '0;
        chk(acc_out == 40'd0, "R11 reset acc", acc_out, 40'd0);
        chk(done == 1'b0, "R11 reset done", {39'd0, done}, 40'd0);
    endtask

    task automatic t_plain();
        pair(16'sd3, 16'sd4, 0, 0, 0, 1, 0, 0, "R1 first pair");
        chk(acc_out == 40'd12, "R1 3*4", acc_out, 40'd12);
        pair(-16'sd5, 16'sd7, 0, 0, 0, 0, 0, 0, "R1 mixed sign");
        pair(-16'sd32768, -16'sd32768, 0, 0, 0, 0, 0, 0, "R1 max product");
        pair(16'sd32767, -16'sd32768, 0, 0, 0, 0, 0, 0, "R1 min product");
        chk(done == 1'b0, "R12 no done outside loop", {39'd0, done}, 40'd0);
        tick();
        chk(acc_out == m_acc, "R1 idle keeps value", acc_out, m_acc);
    endtask

    task automatic t_shape();
        pair(16'sd100, 16'sd200, 0, 0, 0, 1, 0, 0, "R7 clear with pair");
        pair(16'sd30, 16'sd40, 1, 0, 0, 0, 0, 0, "R2 negate");
        chk(acc_out == 40'd18800, "R2 subtract", acc_out, 40'd18800);
        pair(16'sd3, 16'sh4000, 0, 1, 0, 1, 0, 0, "R3 round");
        chk(acc_out == 40'h0000010000, "R3 round value", acc_out, 40'h0000010000);
        pair(16'sd3, 16'sh4000, 1, 1, 0, 1, 0, 0, "R4 neg and round");
        chk(acc_out == 40'hFFFFFF4000, "R4 negation only", acc_out, 40'hFFFFFF4000);
        ctl_clr = 1;
        tick();
        quiet();
        m_acc = '0;
        chk(acc_out == 40'd0, "R7 clear alone", acc_out, 40'd0);
    endtask

    task automatic t_sat();
        pair(16'sd32767, 16'sd32767, 0, 0, 1, 1, 0, 0, "R5 pos step");
        pair(16'sd32767, 16'sd32767, 0, 0, 1, 0, 0, 0, "R5 pos step");
        pair(16'sd32767, 16'sd32767, 0, 0, 1, 0, 0, 0, "R5 pos clamp");
        chk(acc_out == 40'h007FFFFFFF, "R5 upper limit", acc_out, 40'h007FFFFFFF);
        pair(-16'sd32768, 16'sd32767, 0, 0, 1, 1, 0, 0, "R5 neg step");
        pair(-16'sd32768, 16'sd32767, 0, 0, 1, 0, 0, 0, "R5 neg step");
        pair(-16'sd32768, 16'sd32767, 0, 0, 1, 0, 0, 0, "R5 neg clamp");
        chk(acc_out == 40'hFF80000000, "R5 lower limit", acc_out, 40'hFF80000000);
    endtask

    // 512 full-scale products: first loop reaches 2^39, second wraps to 0
    task automatic t_wrap();
        int dones;
        for (int k = 0; k < 2; k++) begin
            dones = 0;
            for (int i = 0; i < 512; i++) begin
                pair(-16'sd32768, -16'sd32768, 0, 0, 0, (k == 0 && i == 0), (i == 0), 14'd512,
                     "R6 wrap step");
                if (done) dones++;
            end
            chk(done == 1'b1 && dones == 1, "R9 wrap loop done once", 40'(dones), 40'd1);
        end
        chk(acc_out == 40'd0, "R6 wrap to zero", acc_out, 40'd0);
    endtask

    task automatic t_repeat();
        int cyc;
        for (int i = 1; i <= 5; i++) begin
            pair(16'sd2, 16'sd3, 0, 0, 0, (i == 1), (i == 1), 14'd5, "R8 loop of 5");
            chk(done == (i == 5), "R9 done timing n=5", {39'd0, done}, {39'd0, (i == 5)});
        end
        chk(acc_out == 40'd30, "R8 five iterations", acc_out, 40'd30);
        tick();
        chk(done == 1'b0, "R9 single cycle pulse", {39'd0, done}, 40'd0);
        pair(16'sd1, 16'sd1, 0, 0, 0, 0, 0, 0, "R12 after loop");
        chk(done == 1'b0, "R12 no done after loop", {39'd0, done}, 40'd0);
        pair(16'sd1, 16'sd1, 0, 0, 0, 0, 1, 14'd1, "R8 count one");
        chk(done == 1'b1, "R9 count one done", {39'd0, done}, 40'd1);
        cyc = 0;
        for (int i = 0; i < 3; i++) begin
            pair(16'sd1, 16'sd1, 0, 0, 0, 0, (i == 0), 14'd0, "R8 count zero");
            if (done) cyc++;
        end
        chk(cyc == 0, "R8 zero count no loop", 40'(cyc), 40'd0);
        cyc = 0;
        for (int i = 0; i < 9000 && cyc == 0; i++) begin
            pair(16'sd1, 16'sd1, 0, 0, 0, (i == 0), (i == 0), 14'd16383, "R8 long loop");
            if (done) cyc = i + 1;
        end
        chk(cyc == 8196, "R8 count clamps to 8196", 40'(cyc), 40'd8196);
        chk(acc_out == 40'd8196, "R8 long loop sum", acc_out, 40'd8196);
    endtask

    task automatic t_hold();
        pair(16'sd1, 16'sd1, 0, 0, 0, 1, 1, 14'd4, "R10 iter 1");
        pair(16'sd1, 16'sd1, 0, 0, 0, 0, 0, 0, "R10 iter 2");
        hold = 1; opnd_valid = 1; opnd_a = 16'd100; opnd_b = 16'd100;
        ctl_clr = 1; rpt_load = 1; rpt_count = 14'd1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(acc_out == 40'd2, "R10 acc frozen", acc_out, 40'd2);
            chk(done == 1'b0, "R10 no done in hold", {39'd0, done}, 40'd0);
        end
        quiet();
        pair(16'sd1, 16'sd1, 0, 0, 0, 0, 0, 0, "R10 iter 3");
        chk(done == 1'b0, "R10 resume not finished", {39'd0, done}, 40'd0);
        pair(16'sd1, 16'sd1, 0, 0, 0, 0, 0, 0, "R10 iter 4");
        chk(done == 1'b1 && acc_out == 40'd4, "R10 resumed loop completes", acc_out, 40'd4);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_shape();
        t_sat();
        t_wrap();
        t_repeat();
        t_hold();
        pair(16'sd7, 16'sd7, 0, 0, 0, 0, 0, 0, "R11 before reset");
        t_reset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule